// File: doc/BRIEF.md
# Register-Mapped Serial Port with Queues

This block is a serial transmitter and receiver reached through a small bank of 32-bit registers. Software writes bytes into a 16-entry transmit queue; the transmitter takes them one at a time and sends each as a frame on the serial output. A frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. No parity bit is sent. The receiver watches the serial input, rebuilds frames and puts good bytes into a 16-entry receive queue. Software reads them from there.

Bit timing comes from an enable input, `base_tick`. A divisor register turns these base ticks into sample ticks. An oversampling register sets how many sample ticks make one bit. Status bits report whether a received byte is waiting, whether the transmit queue is full, and whether the transmitter is completely idle. Software must wait for the idle flag before it changes the bit rate. Two self-clearing control bits flush the queues.

Register byte offsets: receive data 0x00, transmit data 0x04, control 0x08, status 0x0C, divisor 0x10, oversampling 0x14. Any other offset reads as 0, and writes to it have no effect.

Top module: `uart_regmap`

## Requirements
- R1: After reset the serial output is high. Status reads 0x00000040. Control, divisor, oversampling and receive data all read 0.
- R2: A write to offset 0x04 queues `wdata[7:0]`. The transmitter sends the byte as a start bit (0), eight data bits with the least significant bit first, and a stop bit (1). Each bit lasts exactly one bit period, and a frame starts on a sample tick.
- R3: The divisor field is offset 0x10 bits [9:0], where 0 acts as 1. The oversampling field is offset 0x14 bits [5:0], where any value below 4 acts as 16. One bit period is (divisor × oversampling) `base_tick` pulses. Both fields read back as they were written.
- R4: A read of offset 0x00 returns the oldest received byte in bits [7:0], with the upper bits 0, and removes that byte from the queue. When the queue is empty, the read returns 0 and the queue stays as it was.
- R5: Status bit 4 is 1 exactly when the receive queue holds at least one byte.
- R6: Status bit 6 is 1 only when both the transmit queue and the transmit shift register are empty.
- R7: Status bit 11 is 1 when the transmit queue holds 16 bytes. A transmit write while the queue is full is dropped, and the queued bytes are not changed.
- R8: Writing 1 to control bit 14 empties the receive queue. Writing 1 to control bit 15 empties the transmit queue, but a frame already being shifted still finishes. Both bits read back as 0.
- R9: Control bits [13:0] are stored and read back. The frame format is always 8 data bits, no parity and 1 stop bit, which is what a control value of 0 selects.
- R10: The receiver checks the start bit at its midpoint, half a bit period after it sees the falling edge. If the line is high at that point, the frame is discarded and nothing is queued.
- R11: A frame whose stop bit is sampled low is discarded. A good frame that arrives while the receive queue is full is dropped.
- R12: Each queue holds 16 bytes and returns them in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after `rd_en` |
| base_tick | input | 1 | Base timing enable for the divisor |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The result of a register read is due in the cycle after `rd_en` is accepted at a clock edge. A status change caused by a write is seen by the next read. On the serial output, a bit changes on the cycle after a sample tick. A received byte is reported as available in the cycle after the midpoint of its stop bit. The bench drives strobes for one full cycle and samples `rdata` and `txd` on falling edges, so each value is taken one edge after its cause. Bit periods are measured by counting falling edges while `txd` is low, and these counts must match divisor × oversampling exactly. Receive checks poll the status register until the available flag is set, and they fail after a bounded wait.

// File: rtl/uart_regmap_pkg.sv
package uart_regmap_pkg;
    localparam int REG_ADDR_W = 5;

    localparam logic [REG_ADDR_W-1:0] OFS_RXD  = 5'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_TXD  = 5'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_CTL  = 5'h08;
    localparam logic [REG_ADDR_W-1:0] OFS_STAT = 5'h0C;
    localparam logic [REG_ADDR_W-1:0] OFS_BAUD = 5'h10;
    localparam logic [REG_ADDR_W-1:0] OFS_OSR  = 5'h14;

    localparam int ST_RX_AVAIL = 4;
    localparam int ST_TX_EMPTY = 6;
    localparam int ST_TX_FULL  = 11;
    localparam int CTL_RX_CLR  = 14;
    localparam int CTL_TX_CLR  = 15;
    localparam int CTL_KEEP_W  = 14;

    localparam int OSR_DEFAULT = 16;
    localparam int OSR_MIN     = 4;

    typedef enum logic {TX_IDLE, TX_RUN} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = ptr_next(st_q.wp);
            if (do_pop)  st_d.rp = ptr_next(st_q.rp);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem_q[st_q.wp] <= push_data;
    end

    // R7: a push into a full queue leaves it full (entry not accepted)
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);

    // R4: a pop from an empty queue leaves it empty
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> empty);
endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic [DIV_W-1:0] div,
    output logic             sample_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [DIV_W-1:0] div_eff;

    assign div_eff     = (div == '0) ? DIV_W'(1) : div;
    assign sample_tick = base_tick && (st_q.cnt >= div_eff - 1'b1);

    always_comb begin
        st_d = st_q;
        if (base_tick) begin
            st_d.cnt = sample_tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: with a divisor above 1, sample ticks never come on adjacent cycles
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && div_eff > 1) |=> (!sample_tick || div_eff <= 1));
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_regmap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [OSR_W-1:0]  osr,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              txd,
    output logic              busy
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int BIT_W   = $clog2(FRAME_W);

    typedef struct packed {
        tx_state_e          state;
        logic [FRAME_W-1:0] shreg;
        logic [BIT_W-1:0]   bitn;
        logic [OSR_W-1:0]   tcnt;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        fifo_pop = 1'b0;
        case (st_q.state)
            TX_IDLE: begin
                if (tick && !fifo_empty) begin
                    fifo_pop   = 1'b1;
                    st_d.shreg = {1'b1, fifo_data, 1'b0};
                    st_d.bitn  = '0;
                    st_d.tcnt  = '0;
                    st_d.state = TX_RUN;
                end
            end
            default: begin
                if (tick) begin
                    if (st_q.tcnt == osr - 1'b1) begin
                        st_d.tcnt  = '0;
                        st_d.shreg = {1'b1, st_q.shreg[FRAME_W-1:1]};
                        if (st_q.bitn == BIT_W'(FRAME_W - 1)) st_d.state = TX_IDLE;
                        else                                  st_d.bitn  = st_q.bitn + 1'b1;
                    end else begin
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= TX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd  = (st_q.state == TX_RUN) ? st_q.shreg[0] : 1'b1;
    assign busy = (st_q.state == TX_RUN);

    // R2: taking a byte from the queue puts a low start bit on the line next cycle
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == TX_IDLE && tick && !fifo_empty) |=> (txd == 1'b0));

    // R2: the last bit slot of a frame is the high stop bit
    p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == TX_RUN && st_q.bitn == BIT_W'(FRAME_W - 1)) |-> txd);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_regmap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [OSR_W-1:0]  osr,
    input  logic              rxd,
    output logic              push,
    output logic [DATA_W-1:0] data
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         state;
        logic [OSR_W-1:0]  tcnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] shreg;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic line;
    logic [OSR_W-1:0] half;
    logic bit_end;

    assign line    = st_q.sync[1];
    assign half    = osr >> 1;
    assign bit_end = tick && (st_q.tcnt == osr - 1'b1);

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], rxd};
        push      = 1'b0;
        case (st_q.state)
            RX_IDLE: begin
                if (!line) begin
                    st_d.state = RX_START;
                    st_d.tcnt  = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (st_q.tcnt == half - 1'b1) begin
                        st_d.tcnt  = '0;
                        st_d.bitn  = '0;
                        st_d.state = line ? RX_IDLE : RX_DATA;
                    end else begin
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (bit_end) begin
                    st_d.tcnt  = '0;
                    st_d.shreg = {line, st_q.shreg[DATA_W-1:1]};
                    if (st_q.bitn == BIT_W'(DATA_W - 1)) st_d.state = RX_STOP;
                    else                                 st_d.bitn  = st_q.bitn + 1'b1;
                end else if (tick) begin
                    st_d.tcnt = st_q.tcnt + 1'b1;
                end
            end
            default: begin
                if (bit_end) begin
                    push       = line;
                    st_d.tcnt  = '0;
                    st_d.state = RX_IDLE;
                end else if (tick) begin
                    st_d.tcnt = st_q.tcnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.sync  <= 2'b11;
            st_q.state <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign data = st_q.shreg;

    // R10: a line found high at the start-bit midpoint sends the receiver back to idle
    p_mid_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RX_START && tick && st_q.tcnt == half - 1'b1 && line)
            |=> (st_q.state == RX_IDLE));

    // R11: nothing is delivered outside the stop-bit slot
    p_push_in_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (st_q.state == RX_IDLE));
endmodule

// File: rtl/uart_regmap.sv
module uart_regmap
    import uart_regmap_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 10,
    parameter int OSR_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  logic                  base_tick,
    input  logic                  rxd,
    output logic                  txd
);
    typedef struct packed {
        logic [DIV_W-1:0]      baud;
        logic [OSR_W-1:0]      osr;
        logic [CTL_KEEP_W-1:0] ctrl;
        logic [31:0]           rdata;
    } regs_t;

    regs_t rg_d, rg_q;

    logic              sample_tick;
    logic [OSR_W-1:0]  osr_eff;
    logic              tx_push, tx_pop, tx_clr, tx_empty, tx_full, tx_busy;
    logic [DATA_W-1:0] tx_head;
    logic              rx_push, rx_pop, rx_clr, rx_empty, rx_full;
    logic [DATA_W-1:0] rx_head, rx_data;
    logic              ctl_wr;
    logic [31:0]       status;
    logic              unused_bits;

    assign unused_bits = ^{wdata[31:16], rx_full};

    assign osr_eff = (rg_q.osr < OSR_W'(OSR_MIN)) ? OSR_W'(OSR_DEFAULT) : rg_q.osr;
    assign ctl_wr  = wr_en && (addr == OFS_CTL);
    assign tx_clr  = ctl_wr && wdata[CTL_TX_CLR];
    assign rx_clr  = ctl_wr && wdata[CTL_RX_CLR];
    assign tx_push = wr_en && (addr == OFS_TXD);
    assign rx_pop  = rd_en && (addr == OFS_RXD) && !rx_empty;

    always_comb begin
        status              = '0;
        status[ST_RX_AVAIL] = !rx_empty;
        status[ST_TX_EMPTY] = tx_empty && !tx_busy;
        status[ST_TX_FULL]  = tx_full;
    end

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            case (addr)
                OFS_CTL:  rg_d.ctrl = wdata[CTL_KEEP_W-1:0];
                OFS_BAUD: rg_d.baud = wdata[DIV_W-1:0];
                OFS_OSR:  rg_d.osr  = wdata[OSR_W-1:0];
                default:  ;
            endcase
        end
        if (rd_en) begin
            case (addr)
                OFS_RXD:  rg_d.rdata = rx_empty ? '0 : 32'(rx_head);
                OFS_CTL:  rg_d.rdata = 32'(rg_q.ctrl);
                OFS_STAT: rg_d.rdata = status;
                OFS_BAUD: rg_d.rdata = 32'(rg_q.baud);
                OFS_OSR:  rg_d.rdata = 32'(rg_q.osr);
                default:  rg_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign rdata = rg_q.rdata;

    uart_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_tick  (base_tick),
        .div        (rg_q.baud),
        .sample_tick(sample_tick)
    );

    uart_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tx_clr),
        .push     (tx_push),
        .push_data(wdata[DATA_W-1:0]),
        .pop      (tx_pop),
        .head     (tx_head),
        .empty    (tx_empty),
        .full     (tx_full)
    );

    uart_tx #(.DATA_W(DATA_W), .OSR_W(OSR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_tick),
        .osr       (osr_eff),
        .fifo_empty(tx_empty),
        .fifo_data (tx_head),
        .fifo_pop  (tx_pop),
        .txd       (txd),
        .busy      (tx_busy)
    );

    uart_rx #(.DATA_W(DATA_W), .OSR_W(OSR_W)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (sample_tick),
        .osr  (osr_eff),
        .rxd  (rxd),
        .push (rx_push),
        .data (rx_data)
    );

    uart_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_clr),
        .push     (rx_push),
        .push_data(rx_data),
        .pop      (rx_pop),
        .head     (rx_head),
        .empty    (rx_empty),
        .full     (rx_full)
    );

    // R4: reading receive data from an empty queue returns 0
    p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_RXD && rx_empty) |=> (rdata == '0));

    // R8: the receive flush bit leaves the receive queue empty
    p_rx_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[CTL_RX_CLR]) |=> rx_empty);

    // R8: the transmit flush bit leaves the transmit queue empty
    p_tx_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[CTL_TX_CLR]) |=> tx_empty);
endmodule

// File: tb/uart_regmap_bench.sv
module uart_regmap_bench;
    localparam logic [4:0] A_RXD = 5'h00, A_TXD = 5'h04, A_CTL = 5'h08;
    localparam logic [4:0] A_STAT = 5'h0C, A_BAUD = 5'h10, A_OSR = 5'h14;

    // vector: {divisor[3:0], oversampling[5:0], byte[7:0]}
    localparam int NV = 8;
    localparam logic [17:0] VEC [NV] = '{
        {4'd1, 6'd0,  8'h55}, {4'd1, 6'd0,  8'hA3},
        {4'd2, 6'd8,  8'h10}, {4'd3, 6'd5,  8'hFF},
        {4'd1, 6'd2,  8'h37}, {4'd4, 6'd4,  8'hC8},
        {4'd0, 6'd16, 8'h00}, {4'd2, 6'd63, 8'h6B}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic base_tick = 1'b1;
    logic loop_en = 1'b1, bench_rxd = 1'b1;
    logic rxd, txd;
    int errors = 0, checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    assign rxd = loop_en ? txd : bench_rxd;

    uart_regmap u_uart_regmap (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .base_tick(base_tick), .rxd(rxd), .txd(txd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wait_rx(output bit ok);
        logic [31:0] s;
        ok = 1'b0;
        for (int i = 0; i < 20000 && !ok; i++) begin
            reg_read(A_STAT, s);
            ok = s[4];
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop, input int bitc);
        bench_rxd = 1'b0; idle(bitc);
        for (int i = 0; i < 8; i++) begin bench_rxd = b[i]; idle(bitc); end
        bench_rxd = stop; idle(bitc);
        bench_rxd = 1'b1; idle(bitc * 2);
    endtask

    function automatic int low_run(input logic [17:0] v);
        int d, o, tz;
        d  = (v[17:14] == 0) ? 1 : int'(v[17:14]);
        o  = (v[13:8] < 4) ? 16 : int'(v[13:8]);
        tz = 0;
        for (int i = 0; i < 8; i++) begin
            if (v[i]) break;
            tz++;
        end
        return (1 + tz) * d * o;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit ok;
        int cnt;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 txd idle", 32'(txd), 32'd1);
        reg_read(A_STAT, v); check("R1 status", v, 32'h40);
        reg_read(A_CTL, v);  check("R1 ctrl", v, 0);
        reg_read(A_BAUD, v); check("R1 divisor", v, 0);
        reg_read(A_OSR, v);  check("R1 oversampling", v, 0);
        // R4 empty read
        reg_read(A_RXD, v);  check("R4 empty read", v, 0);

        // Table: R2/R3 bit timing and loopback data
        for (int k = 0; k < NV; k++) begin
            reg_write(A_BAUD, 32'(VEC[k][17:14]));
            reg_write(A_OSR, 32'(VEC[k][13:8]));
            reg_read(A_BAUD, v); check("R3 divisor readback", v, 32'(VEC[k][17:14]));
            reg_read(A_OSR, v);  check("R3 oversampling readback", v, 32'(VEC[k][13:8]));
            reg_write(A_TXD, 32'(VEC[k][7:0]));
            for (int g = 0; g < 5000 && txd !== 1'b0; g++) @(negedge clk);
            cnt = 0;
            while (txd === 1'b0 && cnt < 5000) begin cnt++; @(negedge clk); end
            check("R2 R3 leading low run", 32'(cnt), 32'(low_run(VEC[k])));
            reg_read(A_STAT, v); check("R6 busy while sending", 32'(v[6]), 0);
            wait_rx(ok);
            check("R5 byte available", 32'(ok), 1);
            reg_read(A_RXD, v); check("R4 R2 received byte", v, 32'(VEC[k][7:0]));
            reg_read(A_STAT, v); check("R5 queue drained", 32'(v[4]), 0);
            idle(1300);
            reg_read(A_STAT, v); check("R6 idle after frame", 32'(v[6]), 1);
        end
        reg_write(A_BAUD, 1);
        reg_write(A_OSR, 0);

        // R7 full flag and dropped write, drained live
        for (int k = 0; k < 17; k++) reg_write(A_TXD, 32'h40 + 32'(k));
        reg_read(A_STAT, v);
        check("R7 full flag", 32'(v[11]), 1);
        check("R6 not empty when full", 32'(v[6]), 0);
        reg_write(A_TXD, 32'hEE);
        for (int k = 0; k < 17; k++) begin
            wait_rx(ok);
            reg_read(A_RXD, v); check("R7 R12 transmit order", v, 32'h40 + 32'(k));
        end
        idle(500);
        reg_read(A_STAT, v); check("R7 dropped write not sent", v, 32'h40);

        // R12 receive depth, R11 overflow drop
        for (int k = 0; k < 17; k++) reg_write(A_TXD, 32'h60 + 32'(k));
        idle(17 * 180);
        for (int k = 0; k < 16; k++) begin
            reg_read(A_RXD, v); check("R12 receive order", v, 32'h60 + 32'(k));
        end
        reg_read(A_RXD, v); check("R11 byte beyond 16 dropped", v, 0);

        // R8 receive flush and control readback (R9)
        reg_write(A_TXD, 32'h11);
        reg_write(A_TXD, 32'h12);
        idle(400);
        reg_read(A_STAT, v); check("R5 bytes present", 32'(v[4]), 1);
        reg_write(A_CTL, 32'h0000_400A);
        reg_read(A_STAT, v); check("R8 receive flush", 32'(v[4]), 0);
        reg_read(A_RXD, v);  check("R8 flushed read", v, 0);
        reg_read(A_CTL, v);  check("R8 R9 control readback", v, 32'h0000_000A);
        reg_write(A_CTL, 0);
        reg_read(A_CTL, v);  check("R9 control zero", v, 0);

        // R8 transmit flush, frame in flight completes
        for (int k = 0; k < 5; k++) reg_write(A_TXD, 32'h21 + 32'(k));
        reg_write(A_CTL, 32'h0000_8000);
        reg_read(A_STAT, v); check("R8 R6 shifter still busy", v, 32'h0);
        idle(300);
        reg_read(A_STAT, v); check("R8 one frame delivered", v, 32'h50);
        reg_read(A_RXD, v);  check("R8 in-flight byte", v, 32'h21);
        reg_read(A_STAT, v); check("R8 rest flushed", v, 32'h40);

        // R10 start glitch shorter than half a bit
        loop_en = 1'b0; bench_rxd = 1'b1;
        idle(4);
        bench_rxd = 1'b0; idle(4); bench_rxd = 1'b1;
        idle(300);
        reg_read(A_STAT, v); check("R10 glitch discarded", 32'(v[4]), 0);

        // R11 bad stop bit, then a good bench frame
        send_frame(8'h5A, 1'b0, 16);
        idle(100);
        reg_read(A_STAT, v); check("R11 bad stop discarded", 32'(v[4]), 0);
        send_frame(8'hC3, 1'b1, 16);
        reg_read(A_RXD, v); check("R11 good external frame", v, 32'hC3);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule